// File: doc/BRIEF.md
# Window Acknowledge Lockout Gate

This block sits on an asynchronous, strobe-handshaked processor bus in front of a memory-mapped video device. It produces the active-low data-transfer acknowledge for every bus cycle. Cycles outside the video window are acknowledged one clock after the address strobe is seen. Cycles inside the window are acknowledged only when the window is unlocked. A requester that touches a locked window never receives an acknowledge, so it waits until its strobe is withdrawn.

The window unlocks only while a 32-bit key register holds one specific magic word. The key register is written as two 16-bit halves with byte-lane strobes, and it can be read back. A region strap can force the window open regardless of the key. When the window is open, the acknowledge still follows the video device's ready signal, so the device can stretch a cycle. The main processor and a secondary processor reaching the bus through a bridge see the same gating, because the gate looks only at the bus signals and never at who drives them.

Top module: `bus_lockout_gate`

## Requirements
- R1: After a synchronous reset the key register reads as zero, the acknowledge output is high (inactive) and, with the strap low, the window is locked.
- R2: The key register's upper half is at byte address 0xA14000 and its lower half is at 0xA14002. On a write, the upper strobe updates data bits 15:8 and the lower strobe updates bits 7:0; an unselected byte keeps its value. A read of either address returns that half on the read-data output, and all other reads return zero.
- R3: While locked, a cycle to any address from 0xC00000 to 0xDFFFFF never gets an acknowledge, even when the device reports ready.
- R4: A cycle outside the window, including to the key register, gets the acknowledge (low) at the first clock edge that samples the address strobe low, whatever the lock state.
- R5: The window unlocks only while the key equals 0x53454741 (upper half 0x5345, lower half 0x4741). Any later write that changes this value locks the window again.
- R6: While unlocked, a window cycle is acknowledged at the first clock edge where the strobe is low and the device is ready. While the device is not ready, no acknowledge is given.
- R7: With the region strap high, the window behaves as unlocked for any key value.
- R8: The acknowledge goes high at the first clock edge that samples the address strobe high.
- R9: A stalled window cycle that is abandoned leaves no trace: the next cycle outside the window is acknowledged normally and the key is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 23 | Word address, byte-address bits 23:1 |
| bus_wdata | input | 16 | Write data |
| bus_uds_n | input | 1 | Upper byte strobe, active low |
| bus_lds_n | input | 1 | Lower byte strobe, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_as_n | input | 1 | Address strobe, active low |
| vid_ready | input | 1 | Video device ready to complete the cycle |
| region_open | input | 1 | Region strap; high bypasses the lockout |
| bus_rdata | output | 16 | Key register read data, zero otherwise |
| dtack_n | output | 1 | Gated data-transfer acknowledge, active low |

## Verification
On every cycle, the assertions check that a locked window never acknowledges, that an open window waits for ready, that the strap forces an acknowledge, that outside cycles are acknowledged, that the acknowledge releases after the strobe, and that unselected key bytes hold. Only the bench's scenarios can show the full unlock sequence. That covers the partial-write states where one half or one byte of the magic word is in place, relocking after a changed half, readback of both halves, and recovery after an abandoned stalled cycle. Mixed random traffic against a model of the key register covers these orderings further.

// File: rtl/bus_lockout_pkg.sv
package bus_lockout_pkg;

    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int LANES   = DATA_W / 8;
    localparam int KEY_W   = 2 * DATA_W;

    typedef enum logic [1:0] {
        RGN_OTHER  = 2'd0,
        RGN_KEY_HI = 2'd1,
        RGN_KEY_LO = 2'd2,
        RGN_WINDOW = 2'd3
    } region_e;

    typedef struct packed {
        logic             active;
        logic             write;
        logic [LANES-1:0] lanes;
        region_e          region;
    } bus_req_t;

    function automatic region_e classify(
        input logic [ADDR_W-1:0] byte_addr,
        input logic [ADDR_W-1:0] key_base,
        input logic [ADDR_W-1:0] win_lo,
        input logic [ADDR_W-1:0] win_hi
    );
        region_e r;
        if (byte_addr >= win_lo && byte_addr <= win_hi)
            r = RGN_WINDOW;
        else if (byte_addr == key_base)
            r = RGN_KEY_HI;
        else if (byte_addr == key_base + ADDR_W'(2))
            r = RGN_KEY_LO;
        else
            r = RGN_OTHER;
        return r;
    endfunction

endpackage

// File: rtl/lockout_decode.sv
module lockout_decode
    import bus_lockout_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KEY_BASE  = 24'hA14000,
    parameter logic [ADDR_W-1:0] WIN_LO    = 24'hC00000,
    parameter logic [ADDR_W-1:0] WIN_HI    = 24'hDFFFFF
) (
    input  logic [ADDR_W-1:1] addr,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rw,
    input  logic              as_n,
    output bus_req_t          req
);
    always_comb begin
        req.active = ~as_n;
        req.write  = ~rw;
        req.lanes  = {~uds_n, ~lds_n};
        req.region = classify({addr, 1'b0}, KEY_BASE, WIN_LO, WIN_HI);
    end
endmodule

// File: rtl/lockout_key_reg.sv
module lockout_key_reg
    import bus_lockout_pkg::*;
#(
    parameter logic [KEY_W-1:0] MAGIC = 32'h53454741
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              strap,
    output logic [DATA_W-1:0] rdata,
    output logic              unlocked
);
    logic [KEY_W-1:0] key_q;

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam region_e HALF_RGN = (h == 1) ? RGN_KEY_HI : RGN_KEY_LO;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic wr_en;
            assign wr_en = req.active && req.write && req.lanes[l]
                           && (req.region == HALF_RGN);
            always_ff @(posedge clk) begin
                if (rst)
                    key_q[h*DATA_W + l*8 +: 8] <= '0;
                else if (wr_en)
                    key_q[h*DATA_W + l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (req.active && !req.write) begin
            if (req.region == RGN_KEY_HI)
                rdata = key_q[KEY_W-1:DATA_W];
            else if (req.region == RGN_KEY_LO)
                rdata = key_q[DATA_W-1:0];
        end
    end

    assign unlocked = (key_q == MAGIC) || strap;

    // R2: a byte whose strobe is inactive keeps its value
    p_hi_byte_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (req.active && req.write && req.region == RGN_KEY_HI && !req.lanes[1])
        |=> $stable(key_q[KEY_W-1:KEY_W-8]));
    p_lo_byte_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (req.active && req.write && req.region == RGN_KEY_LO && !req.lanes[0])
        |=> $stable(key_q[7:0]));
    // R9: window cycles never touch the key
    p_window_no_key_r9: assert property (@(posedge clk) disable iff (rst)
        (req.active && req.region == RGN_WINDOW) |=> $stable(key_q));
endmodule

// File: rtl/lockout_ack_gate.sv
module lockout_ack_gate
    import bus_lockout_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     unlocked,
    input  logic     vid_ready,
    input  logic     strap,
    output logic     dtack_n
);
    logic dtack_q;

    always_ff @(posedge clk) begin
        if (rst)
            dtack_q <= 1'b1;
        else if (!req.active)
            dtack_q <= 1'b1;
        else if (req.region == RGN_WINDOW)
            dtack_q <= ~(unlocked & vid_ready);
        else
            dtack_q <= 1'b0;
    end

    assign dtack_n = dtack_q;

    p_locked_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (req.active && req.region == RGN_WINDOW && !unlocked) |=> dtack_n);
    p_outside_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (req.active && req.region != RGN_WINDOW) |=> !dtack_n);
    p_wait_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (req.active && req.region == RGN_WINDOW && !vid_ready) |=> dtack_n);
    p_strap_open_r7: assert property (@(posedge clk) disable iff (rst)
        (strap && vid_ready && req.active && req.region == RGN_WINDOW) |=> !dtack_n);
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        !req.active |=> dtack_n);
endmodule

// File: rtl/bus_lockout_gate.sv
module bus_lockout_gate
    import bus_lockout_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KEY_BASE = 24'hA14000,
    parameter logic [ADDR_W-1:0] WIN_LO   = 24'hC00000,
    parameter logic [ADDR_W-1:0] WIN_HI   = 24'hDFFFFF,
    parameter logic [KEY_W-1:0]  MAGIC    = 32'h53454741
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:1] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_uds_n,
    input  logic              bus_lds_n,
    input  logic              bus_rw,
    input  logic              bus_as_n,
    input  logic              vid_ready,
    input  logic              region_open,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dtack_n
);
    bus_req_t req;
    logic     unlocked;

    lockout_decode #(
        .KEY_BASE(KEY_BASE), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_decode (
        .addr(bus_addr), .uds_n(bus_uds_n), .lds_n(bus_lds_n),
        .rw(bus_rw), .as_n(bus_as_n), .req(req)
    );

    lockout_key_reg #(.MAGIC(MAGIC)) u_key (
        .clk(clk), .rst(rst), .req(req), .wdata(bus_wdata),
        .strap(region_open), .rdata(bus_rdata), .unlocked(unlocked)
    );

    lockout_ack_gate u_ack (
        .clk(clk), .rst(rst), .req(req), .unlocked(unlocked),
        .vid_ready(vid_ready), .strap(region_open), .dtack_n(dtack_n)
    );
endmodule

// File: tb/bus_lockout_gate_bench.sv
module bus_lockout_gate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:1] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_uds_n = 1'b1, bus_lds_n = 1'b1, bus_rw = 1'b1, bus_as_n = 1'b1;
    logic        vid_ready = 1'b0, region_open = 1'b0;
    logic [15:0] bus_rdata;
    logic        dtack_n;

    int checks = 0, fails = 0, cycles = 0;
    logic [31:0] mkey = '0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_lockout_gate u_bus_lockout_gate (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_rw(bus_rw),
        .bus_as_n(bus_as_n), .vid_ready(vid_ready), .region_open(region_open),
        .bus_rdata(bus_rdata), .dtack_n(dtack_n)
    );

    function automatic bit in_win(input logic [23:0] a);
        return a >= 24'hC00000 && a <= 24'hDFFFFF;
    endfunction

    function automatic bit is_open();
        return (mkey == 32'h53454741) || region_open;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle; expected outcome from the model.
    task automatic cyc(input logic [23:0] a, input bit rd, input bit u, input bit l,
                       input logic [15:0] d, input bit rdy);
        bit ack;
        logic [15:0] exp_rd;
        ack = in_win(a) ? (is_open() && rdy) : 1'b1;
        exp_rd = '0;
        if (rd && a == 24'hA14000) exp_rd = mkey[31:16];
        if (rd && a == 24'hA14002) exp_rd = mkey[15:0];
        @(negedge clk);
        bus_addr = a[23:1]; bus_rw = rd; bus_uds_n = ~u; bus_lds_n = ~l;
        bus_wdata = d; vid_ready = rdy; bus_as_n = 1'b0;
        @(negedge clk);
        if (ack) begin
            chk(in_win(a) ? "R6" : "R4", {31'd0, dtack_n}, 32'd0);
            if (rd) chk("R2", {16'd0, bus_rdata}, {16'd0, exp_rd});
        end else begin
            chk(is_open() ? "R6" : "R3", {31'd0, dtack_n}, 32'd1);
            repeat (2) begin
                @(negedge clk);
                chk(is_open() ? "R6" : "R3", {31'd0, dtack_n}, 32'd1);
            end
        end
        if (!rd && a == 24'hA14000) begin
            if (u) mkey[31:24] = d[15:8];
            if (l) mkey[23:16] = d[7:0];
        end
        if (!rd && a == 24'hA14002) begin
            if (u) mkey[15:8] = d[15:8];
            if (l) mkey[7:0] = d[7:0];
        end
        bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1; bus_rw = 1'b1;
        @(negedge clk);
        chk("R8", {31'd0, dtack_n}, 32'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [23:0] a;
        logic [15:0] d;
        int sel;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        chk("R1", {31'd0, dtack_n}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, dtack_n}, 32'd1);
        cyc(24'hA14000, 1, 1, 1, 0, 0);               // R1/R2 key reads zero
        cyc(24'hA14002, 1, 1, 1, 0, 0);
        cyc(24'hC00004, 1, 1, 1, 0, 1);               // R3 locked even if ready
        cyc(24'hDFFFFE, 0, 1, 1, 16'h1111, 1);        // R3 top of window
        cyc(24'h000100, 1, 1, 1, 0, 0);               // R4 ROM area
        cyc(24'hE00000, 0, 1, 1, 16'h2222, 0);        // R4 just above window
        cyc(24'hA14000, 0, 1, 1, 16'h5345, 0);        // R5 half the key
        cyc(24'hC00000, 1, 1, 1, 0, 1);               // still locked
        cyc(24'hA14002, 0, 0, 1, 16'hFF41, 0);        // R2 low byte only
        cyc(24'hA14002, 1, 1, 1, 0, 0);
        cyc(24'hC00000, 1, 1, 1, 0, 1);               // still locked
        cyc(24'hA14002, 0, 1, 0, 16'h47EE, 0);        // R2 upper byte completes key
        cyc(24'hA14002, 1, 1, 1, 0, 0);
        cyc(24'hC00000, 1, 1, 1, 0, 1);               // R6 open, ready
        cyc(24'hC00002, 0, 1, 1, 16'h3333, 0);        // R6 open, not ready
        cyc(24'hA14000, 0, 1, 1, 16'h5344, 0);        // R5 relock
        cyc(24'hC00000, 1, 1, 1, 0, 1);               // R9 abandoned stall
        cyc(24'hA14000, 1, 1, 1, 0, 0);               // R9 key unchanged
        cyc(24'h0FF000, 1, 1, 1, 0, 0);               // R9 outside acked
        region_open = 1'b1;
        cyc(24'hC00000, 1, 1, 1, 0, 1);               // R7 strap bypass
        cyc(24'hD00000, 1, 1, 1, 0, 0);               // R7 still waits for ready
        region_open = 1'b0;
        for (int i = 0; i < 600; i++) begin
            sel = $urandom_range(0, 5);
            d = 16'($urandom);
            case (sel)
                0: d = ($urandom_range(0, 1) != 0) ? 16'h5345 : d;
                1: d = ($urandom_range(0, 1) != 0) ? 16'h4741 : d;
                default: ;
            endcase
            case (sel)
                0: a = 24'hA14000;
                1: a = 24'hA14002;
                2: a = ($urandom_range(0, 1) != 0) ? 24'hA14000 : 24'hA14002;
                3: a = {3'b110, 20'($urandom), 1'b0};
                default: a = {3'($urandom_range(0, 5)), 20'($urandom), 1'b0};
            endcase
            if (i % 97 == 0) region_open = ~region_open;
            cyc(a, sel >= 2 ? 1'($urandom) : 1'b0, 1'($urandom), 1'($urandom),
                d, 1'($urandom));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule